// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block is the master side of a serial NOR flash link on a 4-wire SPI bus in mode 0. A client hands it one command at a time through a request port: an instruction byte, an optional 24-bit address, a count of bytes to send and a count of bytes to fetch. The sequencer drops chip select, shifts the instruction, address and outgoing bytes out MSB-first, gathers any incoming bytes, and raises chip select again. Outgoing bytes come from a byte-wide valid/ready stream and incoming bytes leave on another.

The serial clock idles low and is made from the system clock by an even divider. MOSI changes only on the falling side of SCK and MISO is captured on the rising edge. Chip select is high out of reset and stays high for a set number of system clocks between any two commands, so every command begins with a clean high-to-low edge. The outgoing and incoming streams may stall. The sequencer then holds SCK low between bytes and keeps chip select asserted.

When a request sets its poll flag, the sequencer follows the command with a loop of status reads once the command ends. Each loop pass is a complete command that holds chip select low for one status byte. The loop ends on the first status byte whose bit 0 is clear. Status bytes stay inside the block. A one-cycle done pulse marks the end of the whole request.

Top module: `spi_cmd_seq`

## Requirements
- R1: Out of reset and whenever no request is in progress, `spi_cs_n` is 1, `spi_sck` is 0, `busy` is 0 and `req_ready` is 1.
- R2: Every accepted request produces exactly one chip-select low period. The first byte shifted in that period is `req_opcode`, and every byte is sent MSB first.
- R3: Every byte takes exactly eight SCK rising edges. SCK is 0 whenever chip select is high. MOSI changes only while SCK is low, and MISO is sampled on SCK rising edges.
- R4: When `req_has_addr` is 1, the three bytes of `req_addr` follow the opcode in the order [23:16], [15:8], [7:0]. When it is 0, no address bytes are sent.
- R5: After the address, `req_wr_len` bytes are sent, each taken from the write stream in a `wr_valid`/`wr_ready` handshake. A zero length sends none, and one or two bytes serve a status-register write.
- R6: After the written bytes, `req_rd_len` bytes are clocked in and delivered in order on `rd_data`. `rd_valid` stays high with stable data until `rd_ready` is 1. A request with `req_rd_len` 0 delivers nothing, and MISO is ignored during its bytes.
- R7: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. From then until `done`, `busy` is 1 and `req_ready` is 0, and requests offered in that time start no command.
- R8: With `req_poll` set, the command is followed by one or more status reads. Each status read is its own chip-select period made of opcode POLL_OPCODE (default 0x05) and one fetched byte. A new status read is issued while bit 0 of the last status byte is 1, and the loop stops after the first status byte with bit 0 equal to 0. Status bytes never appear on `rd_data`.
- R9: Between the end of one chip-select low period and the start of the next, chip select stays high for at least GAP_CLKS system clocks. This includes the gaps between status reads.
- R10: `done` is a single-cycle pulse. It is issued once per accepted request, after the last chip-select period of that request, and `busy` is 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_opcode | input | 8 | Instruction byte |
| req_has_addr | input | 1 | Send the 24-bit address after the opcode |
| req_addr | input | 24 | Address, sent high byte first |
| req_wr_len | input | LEN_W | Number of bytes to send from the write stream |
| req_rd_len | input | LEN_W | Number of bytes to fetch |
| req_poll | input | 1 | Poll status bit 0 after the command |
| wr_valid | input | 1 | Write stream byte present |
| wr_ready | output | 1 | Write stream byte taken |
| wr_data | input | 8 | Write stream byte |
| rd_valid | output | 1 | Fetched byte present |
| rd_ready | input | 1 | Consumer takes fetched byte |
| rd_data | output | 8 | Fetched byte |
| done | output | 1 | One-cycle end-of-request pulse |
| busy | output | 1 | Request in progress |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest situation to reach is a poll loop that runs several passes. The status byte must keep bit 0 set for a controlled number of reads and then clear it, and the passes must run while the gap timer separates them. The bench's flash responder does this: a chip-erase instruction arms a counter of busy status reads. The bench then counts the chip-select periods carrying the status opcode, and it also confirms that none of those status bytes leak onto the read stream. Stalls on both data streams happen in the middle of a command. The bench reaches them by throttling `wr_valid` and `rd_ready` on a cycle pattern, so SCK has to pause between bytes while chip select stays low.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_NEXT,
        ST_XFER,
        ST_GAP
    } ctl_state_t;

    typedef enum logic [2:0] {
        PH_OP,
        PH_ADDR,
        PH_WR,
        PH_RD,
        PH_FIN
    } phase_t;

    typedef struct packed {
        logic [7:0]  opcode;
        logic        has_addr;
        logic [23:0] addr;
        logic        poll;
    } cmd_t;

    // Address bytes go out high byte first.
    function automatic logic [7:0] addr_byte(input logic [23:0] a, input logic [1:0] idx);
        case (idx)
            2'd0:    return a[23:16];
            2'd1:    return a[15:8];
            default: return a[7:0];
        endcase
    endfunction

endpackage

// File: rtl/spiseq_byte_shifter.sv
module spiseq_byte_shifter #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       byte_done
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    tx_sh;
    logic [7:0]    rx_sh;
    logic          run;
    logic          sck_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            bit_idx <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            run     <= 1'b0;
            sck_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !run) begin
                tx_sh   <= tx_byte;
                run     <= 1'b1;
                cnt     <= '0;
                bit_idx <= '0;
                sck_q   <= 1'b0;
            end else if (run) begin
                if (cnt == CW'(HALF - 1)) begin
                    cnt <= '0;
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                        rx_sh <= {rx_sh[6:0], miso};
                    end else begin
                        sck_q   <= 1'b0;
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                        bit_idx <= bit_idx + 3'd1;
                        if (bit_idx == 3'd7) begin
                            run    <= 1'b0;
                            done_q <= 1'b1;
                        end
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    assign sck       = sck_q;
    assign mosi      = tx_sh[7];
    assign rx_byte   = rx_sh;
    assign byte_done = done_q;

endmodule

// File: rtl/spiseq_ctrl.sv
module spiseq_ctrl
    import spiseq_pkg::*;
#(
    parameter int         LEN_W       = 8,
    parameter int         GAP_CLKS    = 4,
    parameter logic [7:0] POLL_OPCODE = 8'h05
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [7:0]       req_opcode,
    input  logic             req_has_addr,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_wr_len,
    input  logic [LEN_W-1:0] req_rd_len,
    input  logic             req_poll,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             busy,
    output logic             cs_n,
    output logic             sh_start,
    output logic [7:0]       sh_tx,
    input  logic [7:0]       sh_rx,
    input  logic             sh_done
);
    localparam int GW = $clog2(GAP_CLKS + 1);

    ctl_state_t       state;
    phase_t           phase;
    phase_t           post_addr;
    cmd_t             cmd_q;
    logic [LEN_W-1:0] wr_left;
    logic [LEN_W-1:0] rd_left;
    logic [1:0]       aidx;
    logic             in_poll;
    logic             stat_busy;
    logic [GW-1:0]    gap_cnt;
    logic             cs_q;
    logic             done_q;
    logic             rdv_q;
    logic [7:0]       rdd_q;

    always_comb begin
        if (wr_left != '0)      post_addr = PH_WR;
        else if (rd_left != '0) post_addr = PH_RD;
        else                    post_addr = PH_FIN;
    end

    always_comb begin
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        wr_ready = 1'b0;
        if (state == ST_NEXT) begin
            case (phase)
                PH_OP: begin
                    sh_start = 1'b1;
                    sh_tx    = in_poll ? POLL_OPCODE : cmd_q.opcode;
                end
                PH_ADDR: begin
                    sh_start = 1'b1;
                    sh_tx    = addr_byte(cmd_q.addr, aidx);
                end
                PH_WR: begin
                    wr_ready = 1'b1;
                    sh_start = wr_valid;
                    sh_tx    = wr_data;
                end
                PH_RD: begin
                    sh_start = in_poll || !rdv_q;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            phase     <= PH_OP;
            cmd_q     <= '0;
            wr_left   <= '0;
            rd_left   <= '0;
            aidx      <= '0;
            in_poll   <= 1'b0;
            stat_busy <= 1'b0;
            gap_cnt   <= '0;
            cs_q      <= 1'b1;
            done_q    <= 1'b0;
            rdv_q     <= 1'b0;
            rdd_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (rdv_q && rd_ready) rdv_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cmd_q   <= '{opcode: req_opcode, has_addr: req_has_addr,
                                     addr: req_addr, poll: req_poll};
                        wr_left <= req_wr_len;
                        rd_left <= req_rd_len;
                        in_poll <= 1'b0;
                        phase   <= PH_OP;
                        cs_q    <= 1'b0;
                        state   <= ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    if (phase == PH_FIN) begin
                        cs_q    <= 1'b1;
                        gap_cnt <= '0;
                        state   <= ST_GAP;
                    end else if (sh_start) begin
                        state <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (sh_done) begin
                        state <= ST_NEXT;
                        case (phase)
                            PH_OP: begin
                                if (cmd_q.has_addr && !in_poll) begin
                                    phase <= PH_ADDR;
                                    aidx  <= '0;
                                end else begin
                                    phase <= post_addr;
                                end
                            end
                            PH_ADDR: begin
                                if (aidx == 2'd2) phase <= post_addr;
                                else              aidx  <= aidx + 2'd1;
                            end
                            PH_WR: begin
                                wr_left <= wr_left - LEN_W'(1);
                                if (wr_left == LEN_W'(1))
                                    phase <= (rd_left != '0) ? PH_RD : PH_FIN;
                            end
                            PH_RD: begin
                                rd_left <= rd_left - LEN_W'(1);
                                if (in_poll) begin
                                    stat_busy <= sh_rx[0];
                                end else begin
                                    rdv_q <= 1'b1;
                                    rdd_q <= sh_rx;
                                end
                                if (rd_left == LEN_W'(1)) phase <= PH_FIN;
                            end
                            default: phase <= PH_FIN;
                        endcase
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GW'(GAP_CLKS - 1)) begin
                        if (cmd_q.poll && (!in_poll || stat_busy)) begin
                            in_poll <= 1'b1;
                            wr_left <= '0;
                            rd_left <= LEN_W'(1);
                            phase   <= PH_OP;
                            cs_q    <= 1'b0;
                            state   <= ST_NEXT;
                        end else begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end
                    end else begin
                        gap_cnt <= gap_cnt + GW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign busy      = (state != ST_IDLE);
    assign done      = done_q;
    assign cs_n      = cs_q;
    assign rd_valid  = rdv_q;
    assign rd_data   = rdd_q;

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq #(
    parameter int         CLK_DIV     = 4,
    parameter int         GAP_CLKS    = 4,
    parameter int         LEN_W       = 8,
    parameter logic [7:0] POLL_OPCODE = 8'h05
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [7:0]       req_opcode,
    input  logic             req_has_addr,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_wr_len,
    input  logic [LEN_W-1:0] req_rd_len,
    input  logic             req_poll,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             busy,
    output logic             spi_sck,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int HALF = CLK_DIV / 2;

    logic       sh_start;
    logic [7:0] sh_tx;
    logic [7:0] sh_rx;
    logic       sh_done;

    spiseq_ctrl #(
        .LEN_W      (LEN_W),
        .GAP_CLKS   (GAP_CLKS),
        .POLL_OPCODE(POLL_OPCODE)
    ) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_opcode  (req_opcode),
        .req_has_addr(req_has_addr),
        .req_addr    (req_addr),
        .req_wr_len  (req_wr_len),
        .req_rd_len  (req_rd_len),
        .req_poll    (req_poll),
        .wr_valid    (wr_valid),
        .wr_ready    (wr_ready),
        .wr_data     (wr_data),
        .rd_valid    (rd_valid),
        .rd_ready    (rd_ready),
        .rd_data     (rd_data),
        .done        (done),
        .busy        (busy),
        .cs_n        (spi_cs_n),
        .sh_start    (sh_start),
        .sh_tx       (sh_tx),
        .sh_rx       (sh_rx),
        .sh_done     (sh_done)
    );

    spiseq_byte_shifter #(
        .HALF(HALF)
    ) shifter_i (
        .clk      (clk),
        .rst      (rst),
        .start    (sh_start),
        .tx_byte  (sh_tx),
        .miso     (spi_miso),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .rx_byte  (sh_rx),
        .byte_done(sh_done)
    );

endmodule

// File: rtl/spiseq_checker.sv
module spiseq_checker #(
    parameter int GAP_CLKS = 4
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic wr_ready,
    input logic rd_valid,
    input logic rd_ready,
    input logic [7:0] rd_data,
    input logic done,
    input logic busy,
    input logic spi_sck,
    input logic spi_cs_n,
    input logic spi_mosi
);
    localparam int HW = $clog2(GAP_CLKS + 2);

    logic [HW-1:0] hi_cnt;

    // Cycles chip select has been high; it is high throughout reset.
    always_ff @(posedge clk) begin
        if (rst)
            hi_cnt <= HW'(GAP_CLKS);
        else if (!spi_cs_n)
            hi_cnt <= '0;
        else if (hi_cnt < HW'(GAP_CLKS))
            hi_cnt <= hi_cnt + HW'(1);
    end

    a_r1_idle_cs_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> spi_cs_n);

    a_r3_sck_low_cs_high: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    a_r3_mosi_hold_sck_high: assert property (@(posedge clk) disable iff (rst)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    a_r5_wr_inside_frame: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> !spi_cs_n);

    a_r6_rd_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    a_r7_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> busy);

    a_r9_cs_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> (hi_cnt >= HW'(GAP_CLKS)));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind spi_cmd_seq spiseq_checker #(.GAP_CLKS(GAP_CLKS)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .wr_ready (wr_ready),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .done     (done),
    .busy     (busy),
    .spi_sck  (spi_sck),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi)
);

// File: tb/spi_cmd_seq_tb_top.sv
module spi_cmd_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int GAP        = 3;
    localparam int LW         = 8;
    localparam int WATCHDOG   = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [7:0]    req_opcode = 8'h00;
    logic          req_has_addr = 1'b0;
    logic [23:0]   req_addr = '0;
    logic [LW-1:0] req_wr_len = '0;
    logic [LW-1:0] req_rd_len = '0;
    logic          req_poll = 1'b0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [7:0]    wr_data = 8'h00;
    logic          rd_valid;
    logic          rd_ready = 1'b1;
    logic [7:0]    rd_data;
    logic          done;
    logic          busy;
    logic          spi_sck;
    logic          spi_cs_n;
    logic          spi_mosi;
    logic          spi_miso;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_cmd_seq #(
        .CLK_DIV(DIV), .GAP_CLKS(GAP), .LEN_W(LW), .POLL_OPCODE(8'h05)
    ) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_opcode(req_opcode),
        .req_has_addr(req_has_addr), .req_addr(req_addr),
        .req_wr_len(req_wr_len), .req_rd_len(req_rd_len), .req_poll(req_poll),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .done(done), .busy(busy),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // ---------------- behavioural flash responder ----------------
    logic [7:0]  mem [0:255];
    logic [7:0]  out_sh = 8'hFF;
    logic [7:0]  r_in = 8'h00;
    logic [7:0]  r_op = 8'h00;
    logic [23:0] r_addr = '0;
    logic [23:0] r_addr_first = '0;
    logic [6:0]  stat_hi = '0;
    int          busy_reads = 0;
    int          r_bits = 0;
    int          r_bcnt = 0;
    int          rises = 0;
    int          last_bcnt = 0;
    int          cmd_count = 0;
    int          stat_cmds = 0;
    int          sck_err = 0;

    assign spi_miso = out_sh[7];

    initial for (int i = 0; i < 256; i++) mem[i] = 8'hFF;

    always @(negedge spi_cs_n) begin
        r_bits = 0;
        r_bcnt = 0;
        rises  = 0;
        out_sh = 8'hFF;
        cmd_count++;
    end

    always @(posedge spi_cs_n) begin
        if (rises != 8 * r_bcnt || r_bits != 0) sck_err++;
        last_bcnt = r_bcnt;
        if (r_bcnt > 0 && r_op == 8'hC7 && r_bcnt == 1) begin
            for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
            busy_reads = 3;
        end
        if (r_bcnt > 0 && r_op == 8'h05) begin
            stat_cmds++;
            if (busy_reads > 0) busy_reads--;
        end
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            r_in = {r_in[6:0], spi_mosi};
            r_bits++;
            rises++;
            if (r_bits == 8) begin
                r_bits = 0;
                if (r_bcnt == 0) begin
                    r_op = r_in;
                    case (r_in)
                        8'h9F:   out_sh = 8'h3B;
                        8'h05:   out_sh = {stat_hi, (busy_reads != 0)};
                        default: out_sh = 8'hFF;
                    endcase
                end else begin
                    case (r_op)
                        8'h9F: out_sh = (r_bcnt == 1) ? 8'h71 : 8'h16;
                        8'h01: begin
                            if (r_bcnt == 1) stat_hi = r_in[7:1];
                            out_sh = 8'hFF;
                        end
                        8'h03, 8'h02: begin
                            if (r_bcnt <= 3) begin
                                r_addr = {r_addr[15:0], r_in};
                                if (r_bcnt == 3) r_addr_first = r_addr;
                            end else if (r_op == 8'h02) begin
                                mem[r_addr[7:0]] = mem[r_addr[7:0]] & r_in;
                                r_addr = r_addr + 24'd1;
                            end else begin
                                r_addr = r_addr + 24'd1;
                            end
                            if (r_op == 8'h03 && r_bcnt >= 3) out_sh = mem[r_addr[7:0]];
                            else out_sh = 8'hFF;
                        end
                        default: out_sh = 8'hFF;
                    endcase
                end
                r_bcnt++;
            end
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n && r_bits != 0) out_sh = {out_sh[6:0], 1'b1};
    end

    // ---------------- streams and scoreboard ----------------
    logic [7:0] exp_q[$];
    logic [7:0] wr_q[$];
    bit rd_stall = 0;
    bit wr_slow  = 0;
    int done_cnt = 0;

    initial begin
        forever begin
            @(posedge clk);
            if (wr_valid && wr_ready) void'(wr_q.pop_front());
            #1;
            wr_valid = (wr_q.size() > 0) && (!wr_slow || (cyc % 5 == 0));
            wr_data  = (wr_q.size() > 0) ? wr_q[0] : 8'h00;
            rd_ready = rd_stall ? (cyc % 7 == 0) : 1'b1;
        end
    end

    always @(negedge clk) begin
        if (done) done_cnt++;
        if (rd_valid && rd_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected read byte", rd_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R6 read byte", rd_data, e);
            end
        end
    end

    // chip-select high time between frames
    int hi_run = 0;
    int min_gap = 1000000;
    bit seen_low = 0;
    bit prev_cs = 1;
    always @(posedge clk) begin
        if (!rst) begin
            if (spi_cs_n) hi_run++;
            else begin
                if (prev_cs && seen_low && hi_run < min_gap) min_gap = hi_run;
                seen_low = 1;
                hi_run = 0;
            end
            prev_cs = spi_cs_n;
        end
    end

    int n_req = 0;

    task automatic run_cmd(input logic [7:0] op, input bit ha, input logic [23:0] a,
                           input int wl, input int rl, input bit poll);
        while (!req_ready) @(negedge clk);
        req_opcode   = op;
        req_has_addr = ha;
        req_addr     = a;
        req_wr_len   = LW'(wl);
        req_rd_len   = LW'(rl);
        req_poll     = poll;
        req_valid    = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n_req++;
        do @(negedge clk); while (!done);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c0;
        int s0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(spi_cs_n == 1'b1, "R1 cs_n idle", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R1 sck idle", spi_sck, 0);
        chk(busy == 1'b0, "R1 busy idle", busy, 0);
        chk(req_ready == 1'b1, "R1 req_ready idle", req_ready, 1);

        // R2 R6: read identification, 3 bytes, no address
        c0 = cmd_count;
        exp_q.push_back(8'h3B); exp_q.push_back(8'h71); exp_q.push_back(8'h16);
        run_cmd(8'h9F, 0, 24'h0, 0, 3, 0);
        chk(cmd_count == c0 + 1, "R2 one frame per request", cmd_count, c0 + 1);
        chk(r_op == 8'h9F, "R2 opcode first", r_op, 8'h9F);
        chk(last_bcnt == 4, "R2 frame bytes", last_bcnt, 4);

        // R4 R6: read erased area with stalled consumer
        rd_stall = 1;
        for (int i = 0; i < 4; i++) exp_q.push_back(8'hFF);
        run_cmd(8'h03, 1, 24'h5A3C10, 0, 4, 0);
        rd_stall = 0;
        chk(r_addr_first == 24'h5A3C10, "R4 address order", r_addr_first, 24'h5A3C10);
        chk(last_bcnt == 8, "R4 frame bytes", last_bcnt, 8);

        // R5: program three bytes with slow write stream
        wr_slow = 1;
        wr_q.push_back(8'h12); wr_q.push_back(8'h34); wr_q.push_back(8'hF0);
        run_cmd(8'h02, 1, 24'h000020, 3, 0, 0);
        wr_slow = 0;
        chk(wr_q.size() == 0, "R5 write stream drained", wr_q.size(), 0);
        chk(last_bcnt == 7, "R5 program frame bytes", last_bcnt, 7);
        exp_q.push_back(8'h12); exp_q.push_back(8'h34); exp_q.push_back(8'hF0);
        run_cmd(8'h03, 1, 24'h000020, 0, 3, 0);

        // R5: status write with one byte, then with two bytes
        wr_q.push_back(8'h5A);
        run_cmd(8'h01, 0, 24'h0, 1, 0, 0);
        chk(last_bcnt == 2, "R5 one-byte status write", last_bcnt, 2);
        exp_q.push_back(8'h5A);
        run_cmd(8'h05, 0, 24'h0, 0, 1, 0);
        wr_q.push_back(8'hA4); wr_q.push_back(8'h3C);
        run_cmd(8'h01, 0, 24'h0, 2, 0, 0);
        chk(last_bcnt == 3, "R5 two-byte status write", last_bcnt, 3);
        exp_q.push_back(8'hA4);
        run_cmd(8'h05, 0, 24'h0, 0, 1, 0);

        // R7: requests while busy are refused
        c0 = cmd_count;
        for (int i = 0; i < 2; i++) exp_q.push_back(8'hFF);
        fork
            run_cmd(8'h03, 1, 24'h000040, 0, 2, 0);
            begin
                repeat (30) @(negedge clk);
                req_opcode = 8'h9F;
                req_valid  = 1'b1;
                for (int i = 0; i < 6; i++) begin
                    chk(req_ready == 1'b0 && busy == 1'b1, "R7 refuse while busy", req_ready, 0);
                    @(negedge clk);
                end
                req_valid = 1'b0;
            end
        join
        chk(cmd_count == c0 + 1, "R7 no extra frame", cmd_count, c0 + 1);
        chk(r_op == 8'h03, "R7 original opcode kept", r_op, 8'h03);

        // R8: chip erase followed by polling, device busy for three reads
        c0 = cmd_count;
        s0 = stat_cmds;
        run_cmd(8'hC7, 0, 24'h0, 0, 0, 1);
        chk(stat_cmds == s0 + 4, "R8 status reads until clear", stat_cmds, s0 + 4);
        chk(cmd_count == c0 + 5, "R8 frames for erase and polls", cmd_count, c0 + 5);
        chk(busy == 1'b0, "R8 idle after polling", busy, 0);
        for (int i = 0; i < 3; i++) exp_q.push_back(8'hFF);
        run_cmd(8'h03, 1, 24'h000020, 0, 3, 0);

        // R8: polling with device already idle takes one status read
        s0 = stat_cmds;
        wr_q.push_back(8'h00);
        run_cmd(8'h01, 0, 24'h0, 1, 0, 1);
        chk(stat_cmds == s0 + 1, "R8 single status read", stat_cmds, s0 + 1);

        // global checks
        chk(sck_err == 0, "R3 eight rising edges per byte", sck_err, 0);
        chk(min_gap >= GAP, "R9 chip-select high gap", min_gap, GAP);
        chk(done_cnt == n_req, "R10 one done per request", done_cnt, n_req);
        chk(exp_q.size() == 0, "R6 all read bytes delivered", exp_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule